// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes a stereo PCM stream from a three-wire serial link (bit clock, word clock that tells left from right, and serial data) and turns it into parallel samples. Every channel slot on the link is 32 bit clocks long. Once the last bit of a slot arrives, the block presents the sample on a 24-bit output with its most significant bit at bit 23, tags it as left or right, and raises a one-cycle valid strobe for a downstream input buffer.

Run-time configuration chooses delayed framing, where the data starts one bit clock after the word-clock change, or non-delayed framing. It also chooses left or right justification inside the slot, a sample length of 16, 18, 20 or 24 bits, which word-clock level means left, and which bit-clock edge samples the data. In slave mode both clocks come from outside. They pass through synchronisers into the system clock domain, and edges are detected there. In master mode the block divides the system clock to make the bit clock and the word clock itself, and drives them out.

The format fields (framing, justification, word length, word-clock polarity) are latched only at a word-clock transition, so a sample is never assembled under two formats. Mode, bit-clock edge and divider are link set-up fields. They act at once and are meant to be changed only while the link is idle.

Top module: `audio_serial_rx`

## Requirements
- R1: While and right after reset, sampleValid, sampleData, bckOut and wsOut are all 0.
- R2: With cfgRightJust=0 the first N bits of a slot form the sample, MSB first. It appears on sampleData[23:24-N], and sampleData[23-N:0] is 0. Slot bits after the first N are ignored.
- R3: With cfgRightJust=1 the last N bits of the 32-bit slot form the sample, placed as in R2. The leading 32-N bits are ignored.
- R4: cfgWordLen selects N: 2'b00=16, 2'b01=18, 2'b10=20, 2'b11=24.
- R5: With cfgDelayed=1 a slot's first bit is the one sampled one bit clock after the word-clock change. With cfgDelayed=0 it is the bit sampled at the edge where the change is first seen.
- R6: sampleRight is 0 for a left sample and 1 for a right sample. With cfgWsLeftHigh=1, word clock high means left. With cfgWsLeftHigh=0, word clock low means left.
- R7: With cfgBckRise=1 data and word clock are sampled on rising bit-clock edges, and with cfgBckRise=0 on falling edges.
- R8: With cfgMaster=1 the bit clock is driven on bckOut with a high and low time of cfgDivHalf system clocks each (minimum 2). wsOut toggles once every 32 bit-clock periods.
- R9: sampleValid is high for exactly one cycle per completed slot.
- R10: A change of cfgDelayed, cfgRightJust, cfgWordLen or cfgWsLeftHigh made in the middle of a slot does not affect that slot. It applies from the slot that begins at the next word-clock transition.
- R11: In master mode, samples are received against the internally generated clocks, with sdIn as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfgBckRise | input | 1 | 1: sample on rising bit-clock edge, 0: falling |
| cfgDivHalf | input | 8 | Master bit-clock half period in system clocks |
| cfgDelayed | input | 1 | 1: data one bit after word-clock change |
| cfgRightJust | input | 1 | 1: sample occupies the end of the slot |
| cfgWordLen | input | 2 | Sample length code (see R4) |
| cfgWsLeftHigh | input | 1 | 1: word clock high means left |
| bckIn | input | 1 | External bit clock (slave) |
| wsIn | input | 1 | External word clock (slave) |
| sdIn | input | 1 | Serial data |
| bckOut | output | 1 | Generated bit clock (master), 0 in slave |
| wsOut | output | 1 | Generated word clock (master), 0 in slave |
| sampleData | output | 24 | Received sample, MSB-aligned |
| sampleRight | output | 1 | Channel of the sample, 1 = right |
| sampleValid | output | 1 | One-cycle strobe for a new sample |

## Verification
The assertions assume that each external bit-clock level lasts at least two system clocks, so that two valid strobes can never come from neighbouring cycles. They also assume that data and word clock change only on the launch edge, away from the sampling edge. The bench drives every external bit-clock level for four system clocks and changes data and word clock only when the clock moves to its launch level. In master mode it keeps the divider at three. It changes the set-up fields only between streams, and changes a format field in the middle of a slot only in the test written for that purpose.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  // Strobes from the frame control to the datapath, valid in one system cycle
  typedef struct packed {
    logic       bitStrobe;   // a data bit is sampled this cycle
    logic       bitVal;      // the sampled data bit
    logic       capture;     // this bit closes a slot
    logic       chanRight;   // channel of the slot being closed
    logic       rightJust;   // justification of that slot
    logic [1:0] wordLen;     // word length code of that slot
  } rxStrobes_t;

  function automatic int unsigned wordBits(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/asrx_ctrl.sv
module asrx_ctrl
  import asrx_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgBckRise,
  input  logic [DIV_W-1:0] cfgDivHalf,
  input  logic             cfgDelayed,
  input  logic             cfgRightJust,
  input  logic [1:0]       cfgWordLen,
  input  logic             cfgWsLeftHigh,
  input  logic             bckIn,
  input  logic             wsIn,
  input  logic             sdIn,
  output logic             bckOut,
  output logic             wsOut,
  output rxStrobes_t       strb
);

  localparam int POS_W = $clog2(SLOT_BITS) + 1;
  localparam logic [POS_W-1:0] POS_IDLE = '1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_BITS - 1);

  // ---------------- master clock generator ----------------
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divTerm;
  logic [POS_W-1:0] launchCnt;
  logic             bckInt, wsInt;
  logic             launchLevel;

  assign divTerm     = (cfgDivHalf < DIV_W'(2)) ? DIV_W'(1) : cfgDivHalf - DIV_W'(1);
  assign launchLevel = ~cfgBckRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      launchCnt <= '0;
      bckInt    <= 1'b0;
      wsInt     <= 1'b0;
    end else if (!cfgMaster) begin
      divCnt    <= '0;
      launchCnt <= '0;
      bckInt    <= 1'b0;
      wsInt     <= 1'b0;
    end else if (divCnt >= divTerm) begin
      divCnt <= '0;
      bckInt <= ~bckInt;
      if (~bckInt == launchLevel) begin
        if (launchCnt == POS_LAST) begin
          launchCnt <= '0;
          wsInt     <= ~wsInt;
        end else begin
          launchCnt <= launchCnt + 1'b1;
        end
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign bckOut = bckInt;
  assign wsOut  = wsInt;

  // ---------------- synchronisers and edge detection ----------------
  logic [2:0] syncOut;
  logic       bS, wsS, sdS, bPrev;
  logic       bitStrobe;

  asrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({cfgMaster ? bckInt : bckIn, cfgMaster ? wsInt : wsIn, sdIn}),
    .dout (syncOut)
  );

  assign {bS, wsS, sdS} = syncOut;
  assign bitStrobe = cfgBckRise ? (bS & ~bPrev) : (~bS & bPrev);

  // ---------------- slot tracking ----------------
  logic             seen, wsLast, pendStart, slotRight;
  logic [POS_W-1:0] pos, posCur;
  logic             actDelayed, actRightJust, actWsLeftHigh;
  logic [1:0]       actWordLen;
  logic             chg, effDelayed, effLeftHigh, curRight;

  assign chg         = seen & bitStrobe & (wsS ^ wsLast);
  assign effDelayed  = chg ? cfgDelayed : actDelayed;
  assign effLeftHigh = chg ? cfgWsLeftHigh : actWsLeftHigh;
  assign curRight    = wsS ^ effLeftHigh;

  always_comb begin
    if (chg && !effDelayed)   posCur = '0;
    else if (pendStart)       posCur = '0;
    else if (pos == POS_IDLE) posCur = POS_IDLE;
    else                      posCur = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bPrev         <= 1'b0;
      seen          <= 1'b0;
      wsLast        <= 1'b0;
      pendStart     <= 1'b0;
      slotRight     <= 1'b0;
      pos           <= POS_IDLE;
      actDelayed    <= 1'b1;
      actRightJust  <= 1'b0;
      actWsLeftHigh <= 1'b0;
      actWordLen    <= 2'b11;
    end else begin
      bPrev <= bS;
      if (bitStrobe) begin
        seen      <= 1'b1;
        wsLast    <= wsS;
        pos       <= posCur;
        pendStart <= chg & effDelayed;
        if (posCur == '0) slotRight <= curRight;
        if (chg) begin
          actDelayed    <= cfgDelayed;
          actRightJust  <= cfgRightJust;
          actWsLeftHigh <= cfgWsLeftHigh;
          actWordLen    <= cfgWordLen;
        end
      end
    end
  end

  always_comb begin
    strb.bitStrobe = bitStrobe;
    strb.bitVal    = sdS;
    strb.capture   = bitStrobe && (posCur == POS_LAST);
    strb.chanRight = slotRight;
    strb.rightJust = actRightJust;
    strb.wordLen   = actWordLen;
  end

  // ---------------- assertions ----------------
  a_r10_fmt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !chg |=> $stable({actDelayed, actRightJust, actWsLeftHigh, actWordLen}));

  a_r8_ws_on_bck: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $past(cfgMaster) && !$stable(wsInt)) |-> !$stable(bckInt));

  a_r7_real_edge: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> (bS != bPrev));

  a_r2_slot_end: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (pos == POS_LAST));

endmodule

// File: rtl/asrx_datapath.sv
module asrx_datapath
  import asrx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int OUT_W     = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobes_t       strb,
  output logic [OUT_W-1:0] sampleData,
  output logic             sampleRight,
  output logic             sampleValid
);

  logic [SLOT_BITS-1:0] shiftReg, fullSlot, aligned;
  logic [OUT_W-1:0]     keepMask;
  int unsigned          nBits;

  assign fullSlot = {shiftReg[SLOT_BITS-2:0], strb.bitVal};
  assign nBits    = wordBits(strb.wordLen);
  assign aligned  = strb.rightJust ? (fullSlot << (SLOT_BITS - nBits)) : fullSlot;
  assign keepMask = ~({OUT_W{1'b1}} >> nBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sampleData  <= '0;
      sampleRight <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strb.capture;
      if (strb.bitStrobe) shiftReg <= fullSlot;
      if (strb.capture) begin
        sampleData  <= aligned[SLOT_BITS-1 -: OUT_W] & keepMask;
        sampleRight <= strb.chanRight;
      end
    end
  end

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  a_r9_capture_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> sampleValid);

  a_r4_short_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.wordLen == 2'b00) |=> (sampleData[7:0] == 8'h00));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int OUT_W       = 24,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgBckRise,
  input  logic [DIV_W-1:0] cfgDivHalf,
  input  logic             cfgDelayed,
  input  logic             cfgRightJust,
  input  logic [1:0]       cfgWordLen,
  input  logic             cfgWsLeftHigh,
  input  logic             bckIn,
  input  logic             wsIn,
  input  logic             sdIn,
  output logic             bckOut,
  output logic             wsOut,
  output logic [OUT_W-1:0] sampleData,
  output logic             sampleRight,
  output logic             sampleValid
);

  rxStrobes_t strb;

  asrx_ctrl #(
    .SLOT_BITS(SLOT_BITS), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgMaster     (cfgMaster),
    .cfgBckRise    (cfgBckRise),
    .cfgDivHalf    (cfgDivHalf),
    .cfgDelayed    (cfgDelayed),
    .cfgRightJust  (cfgRightJust),
    .cfgWordLen    (cfgWordLen),
    .cfgWsLeftHigh (cfgWsLeftHigh),
    .bckIn         (bckIn),
    .wsIn          (wsIn),
    .sdIn          (sdIn),
    .bckOut        (bckOut),
    .wsOut         (wsOut),
    .strb          (strb)
  );

  asrx_datapath #(.SLOT_BITS(SLOT_BITS), .OUT_W(OUT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sampleData  (sampleData),
    .sampleRight (sampleRight),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;    // system clocks per external bit-clock level

  typedef struct packed {
    logic        delayed;
    logic        rj;
    logic [1:0]  wl;
    logic        leftHigh;
    logic        bckRise;
    logic [23:0] lv;
    logic [23:0] rv;
  } vec_t;

  // R4 word lengths, R5 framing, R6 word-clock polarity, R7 bit-clock edge
  localparam vec_t VECS [0:7] = '{
    '{1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 24'hA1B2C3, 24'h5D6E7F},
    '{1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 24'h123456, 24'hFEDCBA},
    '{1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 24'h89ABCD, 24'h13579B},
    '{1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 24'hC0FFEE, 24'h0BADF0},
    '{1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 24'h7F00FF, 24'h80FF01},
    '{1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 24'h55AA55, 24'hAA55AA},
    '{1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 24'h3FFFC0, 24'h400040},
    '{1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 24'hF0F0F0, 24'h0F0F0F}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgMaster = 1'b0, cfgBckRise = 1'b1, cfgDelayed = 1'b1, cfgRightJust = 1'b0;
  logic cfgWsLeftHigh = 1'b0;
  logic [1:0] cfgWordLen = 2'b11;
  logic [7:0] cfgDivHalf = 8'd3;
  logic bckIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic bckOut, wsOut, sampleRight, sampleValid;
  logic [23:0] sampleData;

  int total = 0, bad = 0, pulseErr = 0, capN = 0;
  logic [23:0] capData [0:511];
  logic        capRight [0:511];
  logic        prevValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_rx i_audio_serial_rx (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgBckRise(cfgBckRise),
    .cfgDivHalf(cfgDivHalf), .cfgDelayed(cfgDelayed), .cfgRightJust(cfgRightJust),
    .cfgWordLen(cfgWordLen), .cfgWsLeftHigh(cfgWsLeftHigh), .bckIn(bckIn),
    .wsIn(wsIn), .sdIn(sdIn), .bckOut(bckOut), .wsOut(wsOut),
    .sampleData(sampleData), .sampleRight(sampleRight), .sampleValid(sampleValid)
  );

  // capture monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (sampleValid && prevValid) pulseErr++;
    prevValid = sampleValid;
    if (sampleValid && capN < 512) begin
      capData[capN]  = sampleData;
      capRight[capN] = sampleRight;
      capN++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] wl);
    return (wl == 2'b00) ? 16 : (wl == 2'b01) ? 18 : (wl == 2'b10) ? 20 : 24;
  endfunction

  function automatic logic [23:0] keepTop(input logic [23:0] v, input logic [1:0] wl);
    return v & ~(24'hFFFFFF >> nb(wl));
  endfunction

  // Streams nBits bits of a repeating left/right frame in the current format.
  // At bit changeAt the word length input switches to newWl.
  task automatic sendStream(input logic [23:0] lv, input logic [23:0] rv, input int nBits,
                            input int changeAt, input logic [1:0] newWl);
    logic [1:0] slotWl = cfgWordLen;
    for (int i = 0; i < nBits; i++) begin
      int p = i % 32;
      int n;
      logic rightSlot = ((i / 32) % 2) == 1;
      int j = cfgDelayed ? i + 1 : i;
      logic wsRight = ((j / 32) % 2) == 1;
      logic [23:0] val = rightSlot ? rv : lv;
      logic b;
      if (i == changeAt) cfgWordLen = newWl;
      if (p == 0) slotWl = cfgWordLen;
      n = nb(slotWl);
      if (!cfgRightJust) b = (p < n) ? val[23-p] : 1'b1;
      else               b = (p >= 32 - n) ? val[23-(p-(32-n))] : 1'b1;
      bckIn = ~cfgBckRise;
      wsIn  = wsRight ^ cfgWsLeftHigh;
      sdIn  = b;
      repeat (H) @(negedge clk);
      bckIn = cfgBckRise;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'b0, sampleValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 data after reset", {8'b0, sampleData}, 32'd0);
    chk("R1 clocks out low", {30'b0, bckOut, wsOut}, 32'd0);

    // table walk: R2/R3 placement under each format
    for (int v = 0; v < 8; v++) begin
      vec_t t = VECS[v];
      int start;
      string tag;
      cfgDelayed    = t.delayed;
      cfgRightJust  = t.rj;
      cfgWordLen    = t.wl;
      cfgWsLeftHigh = t.leftHigh;
      cfgBckRise    = t.bckRise;
      start = capN;
      sendStream(t.lv, t.rv, 194, -1, t.wl);
      repeat (8) @(negedge clk);
      tag = $sformatf("%s R4 R5 R6 R7 vec%0d", t.rj ? "R3" : "R2", v);
      chk({tag, " count"}, 32'((capN - start) >= 4), 32'd1);
      chk({tag, " left"},  {7'b0, capRight[capN-2], capData[capN-2]}, {8'b0, keepTop(t.lv, t.wl)});
      chk({tag, " right"}, {7'b0, capRight[capN-1], capData[capN-1]}, {7'b0, 1'b1, keepTop(t.rv, t.wl)});
    end

    // R10: word length changed in the middle of a left slot
    cfgDelayed = 1'b0; cfgRightJust = 1'b0; cfgWordLen = 2'b11;
    cfgWsLeftHigh = 1'b0; cfgBckRise = 1'b1;
    bckIn = 1'b0; wsIn = 1'b0;
    doReset();
    capN = 0;
    sendStream(24'hA5C3F1, 24'h3C5A96, 130, 74, 2'b00);
    repeat (8) @(negedge clk);
    chk("R10 capture count", 32'(capN >= 3), 32'd1);
    chk("R10 slot in progress keeps 24 bits", {7'b0, capRight[1], capData[1]}, {8'b0, 24'hA5C3F1});
    chk("R10 next slot uses 16 bits", {7'b0, capRight[2], capData[2]}, {7'b0, 1'b1, 24'h3C5A00});

    // R8/R11: master mode with divider 3
    cfgWordLen = 2'b11; cfgMaster = 1'b1; cfgDivHalf = 8'd3; sdIn = 1'b1;
    begin
      int gap;
      logic o;
      o = bckOut;
      do @(negedge clk); while (bckOut == o);
      o = bckOut; gap = 0;
      do begin @(negedge clk); gap++; end while (bckOut == o && gap < 1000);
      chk("R8 bit clock half period", gap, 32'd3);
      o = wsOut;
      do @(negedge clk); while (wsOut == o);
      o = wsOut; gap = 0;
      do begin @(negedge clk); gap++; end while (wsOut == o && gap < 2000);
      chk("R8 word clock half period", gap, 32'd192);
    end
    capN = 0;
    repeat (900) @(negedge clk);
    chk("R11 master captures", 32'(capN >= 4), 32'd1);
    chk("R11 master data", {8'b0, capData[capN-1]}, {8'b0, 24'hFFFFFF});
    chk("R11 channels alternate", 32'(capRight[capN-1] != capRight[capN-2]), 32'd1);
    cfgMaster = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 slave clocks low", {30'b0, bckOut, wsOut}, 32'd0);

    // R9: every strobe lasted one cycle
    chk("R9 single-cycle valid", pulseErr, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule